// File: doc/BRIEF.md
# Line-Windowed Bus Activity Counter

This statistics unit sits beside a memory-bus decoder and uses an active-low line-sync input to define measurement windows. Every clock cycle is one sample of the bus. In each window it counts the rising edges of two clock-like bus lines, called strobe A and strobe B, and the number of samples in the window. Each sync transition, falling or rising, ends the current window. At that transition the unit publishes the three counts in held output registers with a one-cycle strobe, and then starts a new window from zero.

A second group of counters follows memory reads per display line. The decoder gives a one-cycle pulse for each decoded RAM read, with the read address. It also gives a pulse each time a column address is latched, for a normal access or a transfer. The unit counts reads. It also counts repeated reads, which are reads whose address matches the most recently latched column address. It publishes both totals only on the falling sync transition, and only when at least one read was seen. The host does any conversion into frequencies.

Top module: `line_activity_counter`

## Requirements
- R1: While reset is asserted, and until the first report after reset, every count output is zero and both strobes are low.
- R2: A rising edge of strobe A is a sample at 1 whose previous sample was 0. No edge is detected on the first sample after reset. `win_cnt_a` reports the rising edges sampled from the sample after the opening sync transition up to and including the closing sync-transition sample.
- R3: `win_cnt_b` reports the strobe B rising edges over the same span, with the same edge rule as R2.
- R4: `win_len` reports the number of clock cycles from the opening sync-transition sample to the closing one. Transitions on consecutive samples give 1.
- R5: A sync transition is a sample of `line_sync_n` that differs from the previous sample, in either direction. Each transition closes the open window and opens a new one. The first transition after reset opens a window without a report. `win_stb` is high for one cycle, in the cycle after the clock edge that sampled the closing transition, and the window outputs update at that same edge.
- R6: Window outputs change only when `win_stb` is high. Read outputs change only when `rd_stb` is high.
- R7: The last-address register loads `col_addr` on every `col_latch` pulse. After reset it holds no valid address, so no read counts as repeated until a column has been latched.
- R8: `rd_total` reports the `ram_rd` pulses from one falling sync-transition sample, inclusive, up to the next falling sync-transition sample, exclusive. Rising transitions do not affect read counting.
- R9: `rd_repeat` reports the counted reads whose `rd_addr` equals the last-address register value held before that cycle's `col_latch`.
- R10: `rd_stb` pulses, and the read outputs update, only at a falling sync transition whose line read count is nonzero. A falling transition with zero reads leaves `rd_stb` low and holds the read outputs.
- R11: Every counter saturates at 2^CW-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_sync_n | input | 1 | Active-low line sync sample |
| strobe_a | input | 1 | First clock-like bus line sample |
| strobe_b | input | 1 | Second clock-like bus line sample |
| ram_rd | input | 1 | Decoded RAM read pulse |
| rd_addr | input | AW | Address of the decoded read |
| col_latch | input | 1 | Column-address latch pulse (any access kind) |
| col_addr | input | AW | Latched column address |
| win_stb | output | 1 | Window report strobe |
| win_cnt_a | output | CW | Strobe A rising edges in last window |
| win_cnt_b | output | CW | Strobe B rising edges in last window |
| win_len | output | CW | Samples in last window |
| rd_stb | output | 1 | Read report strobe |
| rd_total | output | CW | Reads in last line |
| rd_repeat | output | CW | Repeated reads in last line |

## Verification
On every cycle, the assertions check the following: each strobe traces back to a sync transition of the right polarity; the held outputs stay stable between strobes; a reported window is never empty; a read report is nonzero and never shows more repeats than reads. Only the bench scenarios can show the count values themselves. These are the edge totals, the window lengths at back-to-back transitions, the repeat matching against the latched column address, and saturation. For this, the bench runs a reference model against random and directed bus activity.

// File: rtl/lac_pkg.sv
package lac_pkg;
  // bit positions inside the bus sample vector handled by the edge detector
  localparam int unsigned SYNC_IDX  = 0;
  localparam int unsigned CKA_IDX   = 1;
  localparam int unsigned CKB_IDX   = 2;
  localparam int unsigned N_TRACKED = 3;

  typedef enum logic [1:0] {
    WIN_IDLE = 2'b00,
    WIN_OPEN = 2'b01
  } win_state_e;
endpackage

// File: rtl/lac_rst_sync.sv
module lac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lac_edge_det.sv
module lac_edge_det #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;
  logic         primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= sig_i;
      primed_q <= 1'b1;
    end
  end

  // no transitions are reported until one sample has been seen
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rise_o[i] = primed_q &  sig_i[i] & ~prev_q[i];
    assign fall_o[i] = primed_q & ~sig_i[i] &  prev_q[i];
  end
endmodule

// File: rtl/lac_window.sv
module lac_window
  import lac_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cka_rise,
  input  logic          ckb_rise,
  input  logic          sync_edge,
  output logic          rep_stb,
  output logic [CW-1:0] rep_a,
  output logic [CW-1:0] rep_b,
  output logic [CW-1:0] rep_len
);
  localparam logic [CW-1:0] CMAX = '1;

  win_state_e    st_q, st_d;
  logic [CW-1:0] cnt_a_q, cnt_a_d, cnt_b_q, cnt_b_d, len_q, len_d;
  logic [CW-1:0] inc_a, inc_b, inc_len;
  logic          stb_d;
  logic          out_en;
  logic [CW-1:0] rep_a_d, rep_b_d, rep_len_d;

  // saturating increments that include the current sample
  assign inc_a   = (cnt_a_q == CMAX || !cka_rise) ? cnt_a_q : cnt_a_q + 1'b1;
  assign inc_b   = (cnt_b_q == CMAX || !ckb_rise) ? cnt_b_q : cnt_b_q + 1'b1;
  assign inc_len = (len_q == CMAX) ? len_q : len_q + 1'b1;

  always_comb begin
    st_d      = st_q;
    cnt_a_d   = inc_a;
    cnt_b_d   = inc_b;
    len_d     = (st_q == WIN_OPEN) ? inc_len : len_q;
    stb_d     = 1'b0;
    out_en    = 1'b0;
    rep_a_d   = inc_a;
    rep_b_d   = inc_b;
    rep_len_d = inc_len;
    if (sync_edge) begin
      if (st_q == WIN_OPEN) begin
        stb_d  = 1'b1;
        out_en = 1'b1;
      end
      st_d    = WIN_OPEN;
      cnt_a_d = '0;
      cnt_b_d = '0;
      len_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WIN_IDLE;
      cnt_a_q <= '0;
      cnt_b_q <= '0;
      len_q   <= '0;
      rep_stb <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_a_q <= cnt_a_d;
      cnt_b_q <= cnt_b_d;
      len_q   <= len_d;
      rep_stb <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_a   <= '0;
      rep_b   <= '0;
      rep_len <= '0;
    end else if (out_en) begin
      rep_a   <= rep_a_d;
      rep_b   <= rep_b_d;
      rep_len <= rep_len_d;
    end
  end
endmodule

// File: rtl/lac_reads.sv
module lac_reads #(
  parameter int unsigned CW = 16,
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ram_rd,
  input  logic [AW-1:0] rd_addr,
  input  logic          col_latch,
  input  logic [AW-1:0] col_addr,
  input  logic          sync_fall,
  output logic          rep_stb,
  output logic [CW-1:0] rep_total,
  output logic [CW-1:0] rep_repeat
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [AW-1:0] last_q, last_d;
  logic          last_v_q, last_v_d;
  logic [CW-1:0] tot_q, tot_d, rep_q, rep_d;
  logic          hit;
  logic          stb_d, out_en;

  assign hit = ram_rd & last_v_q & (rd_addr == last_q);

  always_comb begin
    last_d   = col_latch ? col_addr : last_q;
    last_v_d = last_v_q | col_latch;
    stb_d    = 1'b0;
    out_en   = 1'b0;
    if (sync_fall) begin
      if (tot_q != '0) begin
        stb_d  = 1'b1;
        out_en = 1'b1;
      end
      tot_d = {{(CW-1){1'b0}}, ram_rd};
      rep_d = {{(CW-1){1'b0}}, hit};
    end else begin
      tot_d = (tot_q == CMAX || !ram_rd) ? tot_q : tot_q + 1'b1;
      rep_d = (rep_q == CMAX || !hit)    ? rep_q : rep_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q   <= '0;
      last_v_q <= 1'b0;
      tot_q    <= '0;
      rep_q    <= '0;
      rep_stb  <= 1'b0;
    end else begin
      last_q   <= last_d;
      last_v_q <= last_v_d;
      tot_q    <= tot_d;
      rep_q    <= rep_d;
      rep_stb  <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_total  <= '0;
      rep_repeat <= '0;
    end else if (out_en) begin
      rep_total  <= tot_q;
      rep_repeat <= rep_q;
    end
  end
endmodule

// File: rtl/line_activity_counter.sv
module line_activity_counter
  import lac_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_sync_n,
  input  logic          strobe_a,
  input  logic          strobe_b,
  input  logic          ram_rd,
  input  logic [AW-1:0] rd_addr,
  input  logic          col_latch,
  input  logic [AW-1:0] col_addr,
  output logic          win_stb,
  output logic [CW-1:0] win_cnt_a,
  output logic [CW-1:0] win_cnt_b,
  output logic [CW-1:0] win_len,
  output logic          rd_stb,
  output logic [CW-1:0] rd_total,
  output logic [CW-1:0] rd_repeat
);
  logic                 rst_n_int;
  logic [N_TRACKED-1:0] bus_vec, rise, fall;

  lac_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  always_comb begin
    bus_vec           = '0;
    bus_vec[SYNC_IDX] = line_sync_n;
    bus_vec[CKA_IDX]  = strobe_a;
    bus_vec[CKB_IDX]  = strobe_b;
  end

  lac_edge_det #(.N(N_TRACKED)) edge_i (
    .clk(clk), .rst_n(rst_n_int), .sig_i(bus_vec), .rise_o(rise), .fall_o(fall)
  );

  lac_window #(.CW(CW)) win_i (
    .clk(clk), .rst_n(rst_n_int),
    .cka_rise(rise[CKA_IDX]), .ckb_rise(rise[CKB_IDX]),
    .sync_edge(rise[SYNC_IDX] | fall[SYNC_IDX]),
    .rep_stb(win_stb), .rep_a(win_cnt_a), .rep_b(win_cnt_b), .rep_len(win_len)
  );

  lac_reads #(.CW(CW), .AW(AW)) rd_i (
    .clk(clk), .rst_n(rst_n_int),
    .ram_rd(ram_rd), .rd_addr(rd_addr),
    .col_latch(col_latch), .col_addr(col_addr),
    .sync_fall(fall[SYNC_IDX]),
    .rep_stb(rd_stb), .rep_total(rd_total), .rep_repeat(rd_repeat)
  );
endmodule

// File: rtl/lac_checker.sv
module lac_checker #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_sync_n,
  input logic          win_stb,
  input logic [CW-1:0] win_cnt_a,
  input logic [CW-1:0] win_cnt_b,
  input logic [CW-1:0] win_len,
  input logic          rd_stb,
  input logic [CW-1:0] rd_total,
  input logic [CW-1:0] rd_repeat
);
  // R5
  win_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_stb |-> ($past(line_sync_n) != $past(line_sync_n, 2)));

  // R10
  rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> ($past(line_sync_n, 2) && !$past(line_sync_n)));

  // R10
  rd_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> (rd_total != '0));

  // R9
  repeat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> (rd_repeat <= rd_total));

  // R4
  len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_stb |-> (win_len != '0));

  // R6
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_stb |-> ($stable(win_cnt_a) && $stable(win_cnt_b) && $stable(win_len)));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |-> ($stable(rd_total) && $stable(rd_repeat)));
endmodule

bind line_activity_counter lac_checker #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .line_sync_n(line_sync_n),
  .win_stb(win_stb), .win_cnt_a(win_cnt_a), .win_cnt_b(win_cnt_b),
  .win_len(win_len), .rd_stb(rd_stb), .rd_total(rd_total), .rd_repeat(rd_repeat)
);

// File: tb/line_activity_counter_tb_top.sv
module line_activity_counter_tb_top;
  localparam int CLK_P = 10;
  localparam int CW    = 10;
  localparam int AW    = 4;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          line_sync_n, strobe_a, strobe_b, ram_rd, col_latch;
  logic [AW-1:0] rd_addr, col_addr;
  logic          win_stb, rd_stb;
  logic [CW-1:0] win_cnt_a, win_cnt_b, win_len, rd_total, rd_repeat;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  line_activity_counter #(.CW(CW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_sync_n(line_sync_n),
    .strobe_a(strobe_a), .strobe_b(strobe_b), .ram_rd(ram_rd), .rd_addr(rd_addr),
    .col_latch(col_latch), .col_addr(col_addr),
    .win_stb(win_stb), .win_cnt_a(win_cnt_a), .win_cnt_b(win_cnt_b), .win_len(win_len),
    .rd_stb(rd_stb), .rd_total(rd_total), .rd_repeat(rd_repeat)
  );

  // reference model state
  int m_ps, m_pa, m_pb, m_primed, m_open;
  int m_ca, m_cb, m_len, m_rd, m_red, m_last, m_lv;
  int e_wstb, e_a, e_b, e_len, e_rstb, e_tot, e_rep;

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  function automatic void model_step(input int s, a, b, rd, ra, cl, ca);
    int ra_rise, rb_rise, hs_edge, hs_fall, hit;
    ra_rise = m_primed && a && !m_pa;
    rb_rise = m_primed && b && !m_pb;
    hs_edge = m_primed && (s != m_ps);
    hs_fall = m_primed && m_ps && !s;
    e_wstb = 0;
    e_rstb = 0;
    if (hs_edge) begin
      if (m_open) begin
        e_a = sat(m_ca + ra_rise); e_b = sat(m_cb + rb_rise);
        e_len = sat(m_len + 1); e_wstb = 1;
      end
      m_ca = 0; m_cb = 0; m_len = 0; m_open = 1;
    end else begin
      m_ca = sat(m_ca + ra_rise); m_cb = sat(m_cb + rb_rise);
      if (m_open) m_len = sat(m_len + 1);
    end
    hit = rd && m_lv && (ra == m_last);
    if (hs_fall) begin
      if (m_rd != 0) begin e_tot = m_rd; e_rep = m_red; e_rstb = 1; end
      m_rd = rd; m_red = hit;
    end else begin
      m_rd = sat(m_rd + rd); m_red = sat(m_red + hit);
    end
    if (cl) begin m_last = ca; m_lv = 1; end
    m_ps = s; m_pa = a; m_pb = b; m_primed = 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R5 win_stb", int'(win_stb), e_wstb);
    chk("R2 win_cnt_a", int'(win_cnt_a), e_a);
    chk("R3 win_cnt_b", int'(win_cnt_b), e_b);
    chk("R4 win_len", int'(win_len), e_len);
    chk("R10 rd_stb", int'(rd_stb), e_rstb);
    chk("R8 rd_total", int'(rd_total), e_tot);
    chk("R9 R7 rd_repeat", int'(rd_repeat), e_rep);
  endtask

  // one sample: check outputs of the previous sample, then drive the next
  task automatic cyc(input int s, a, b, rd, ra, cl, ca);
    @(negedge clk);
    compare_all();
    line_sync_n = s[0]; strobe_a = a[0]; strobe_b = b[0];
    ram_rd = rd[0]; rd_addr = ra[AW-1:0]; col_latch = cl[0]; col_addr = ca[AW-1:0];
    model_step(s, a, b, rd, ra, cl, ca);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog R1..all: actual=timeout expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed, s;
    seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0;
    line_sync_n = 1'b0; strobe_a = 1'b0; strobe_b = 1'b0;
    ram_rd = 1'b0; rd_addr = '0; col_latch = 1'b0; col_addr = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 win_stb", int'(win_stb), 0);
    chk("R1 win_len", int'(win_len), 0);
    chk("R1 win_cnt_a", int'(win_cnt_a), 0);
    chk("R1 rd_stb", int'(rd_stb), 0);
    chk("R1 rd_total", int'(rd_total), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 win_cnt_b after release", int'(win_cnt_b), 0);
    chk("R1 rd_repeat after release", int'(rd_repeat), 0);
    // DUT is now primed with all previous samples at zero
    m_ps = 0; m_pa = 0; m_pb = 0; m_primed = 1; m_open = 0;
    m_ca = 0; m_cb = 0; m_len = 0; m_rd = 0; m_red = 0; m_last = 0; m_lv = 0;
    e_wstb = 0; e_a = 0; e_b = 0; e_len = 0; e_rstb = 0; e_tot = 0; e_rep = 0;

    // R7: a read before any column latch is never a repeat
    cyc(1, 0, 0, 1, 0, 0, 0);
    cyc(1, 0, 0, 1, 0, 1, 5);
    cyc(1, 0, 0, 1, 5, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R7 R8 first line total", int'(rd_total), 3);
    chk("R7 R9 first line repeats", int'(rd_repeat), 1);

    // R4 R5: back-to-back sync transitions give one-sample windows
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk("R4 one-sample window", int'(win_len), 1);
    // R10: falling transition with zero reads gives no read report
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R10 no strobe on empty line", int'(rd_stb), 0);
    chk("R10 total held", int'(rd_total), 3);

    // random traffic
    s = 0;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(19) == 0) s = 1 - s;
      cyc(s, int'($urandom_range(1)), int'($urandom_range(1)),
          int'($urandom_range(3) == 0), int'($urandom_range(3)),
          int'($urandom_range(3) == 0), int'($urandom_range(3)));
    end

    // R11: saturation over a long window, closed by a falling transition
    cyc(1, 0, 0, 0, 0, 1, 9);
    for (int i = 0; i < 2200; i++) cyc(1, i % 2, i % 2, 1, 9, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R11 win_len saturated", int'(win_len), CMAX);
    chk("R11 win_cnt_a saturated", int'(win_cnt_a), CMAX);
    chk("R11 rd_total saturated", int'(rd_total), CMAX);
    chk("R11 rd_repeat saturated", int'(rd_repeat), CMAX);

    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(7) == 0) s = 1 - s;
      cyc(s, int'($urandom_range(1)), int'($urandom_range(1)),
          int'($urandom_range(1)), int'($urandom_range(1)),
          int'($urandom_range(1)), int'($urandom_range(1)));
    end
    @(negedge clk);
    compare_all();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule